// File: doc/BRIEF.md
# Serial Command Frame Transmitter

This block turns host command requests into serial frames for a configuration microcontroller. The link has two wires: a data line and a clock line, both driven by this block. A third wire, a busy/reject line, comes back from the peer. The host presents an opcode with zero to three argument bytes on a valid/ready command port. The host may also mark the command as carrying a data payload. In that case a valid/ready byte stream supplies exactly the programmed number of payload bytes.

Every frame opens with a fixed prefix byte, then the opcode, then the arguments, then any payload. Each byte goes out with its most significant bit first. The peer latches data on each rising clock edge. The length of each clock phase comes from a divider input, so the bit rate can be set to whatever the peer requires. The busy line passes through a synchronizer before use, and its meaning depends on the part of the frame being sent:

- **Header bytes** (prefix, opcode and arguments): a high level means the peer refused the command. The frame stops after the current byte and ends with a rejected status.
- **Payload bytes**: a high level means the peer is writing flash. The block holds off before the next payload byte until the line falls.

Back-pressure rules:

- **Command port**: `cmd_ready` is high only while no frame is in progress. A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high.
- **Payload port**: `pl_ready` is raised for one cycle, and only while `pl_valid` is high. A byte is consumed on each cycle where both are high. A low `pl_valid` stalls the frame with the link clock low, for as long as it takes.

Top module: `cfg_link_tx`

## Requirements
- R1: Each byte is shifted out MSB first. `link_dat` is stable for the whole time `link_clk` is high, so the peer can sample it on the rising edge.
- R2: Every frame starts with the prefix byte 0x88, followed by the opcode byte `cmd_opcode`.
- R3: After the opcode, `cmd_nargs` (0 to 3) argument bytes follow, taken from `cmd_args` in the order [7:0], [15:8], [23:16]. This is the low, middle, high order of a 24-bit value.
- R4: When `cmd_with_data` is 1, exactly 64 payload bytes follow the arguments, in the order accepted on the payload port. `pl_ready` is high only while `pl_valid` is high and `link_clk` is low.
- R5: Each high phase and each low phase of `link_clk` inside a byte lasts `half_period` clock cycles; a value of 0 or 1 gives 1 cycle. `link_clk` and `link_dat` are both 0 between frames.
- R6: The busy input is synchronized by two flops. If the synchronized busy is high while a header byte is being shifted, the frame ends after that byte and `status` is 1 (REJECTED).
- R7: If the synchronized busy is high when a payload byte would start, no rising edge of `link_clk` occurs until busy falls. The frame then completes normally.
- R8: `done` is a one-cycle pulse at the end of every frame. `status` is valid with it: 0 means OK, 1 means REJECTED.
- R9: After reset `cmd_ready` is 1 and `done` is 0. `cmd_ready` stays 0 from the acceptance of a command until its `done`, so start requests made during a frame are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_period | input | DIV_W | Clock cycles per link clock phase |
| cmd_valid | input | 1 | Command request valid |
| cmd_ready | output | 1 | Block idle, command accepted when valid |
| cmd_opcode | input | 8 | Opcode byte |
| cmd_nargs | input | 2 | Number of argument bytes (0-3) |
| cmd_args | input | 24 | Argument bytes, [7:0] sent first |
| cmd_with_data | input | 1 | Frame carries a payload |
| pl_valid | input | 1 | Payload byte valid |
| pl_ready | output | 1 | Payload byte taken this cycle |
| pl_data | input | 8 | Payload byte |
| link_dat | output | 1 | Serial data line |
| link_clk | output | 1 | Serial clock line |
| link_busy | input | 1 | Busy/reject line from the peer (asynchronous) |
| done | output | 1 | End-of-frame pulse |
| status | output | 1 | 0 = OK, 1 = REJECTED, valid with done |

## Verification
The checker watches several properties on every cycle:
- data stability across each high phase of the link clock;
- that no clock phase is longer than the divider setting;
- quiet link lines while idle;
- that payload is taken only with valid and with the clock low;
- the single-cycle done pulse and the drop of `cmd_ready` after acceptance.

Some behaviour only the bench scenarios can show, because it depends on what the peer sees. These are byte order and content, exact phase lengths under a sweep of divider values and argument counts, truncation and status after busy is raised in different header bytes, and the absence of clock edges while busy holds back the payload.

// File: rtl/cfg_link_pkg.sv
package cfg_link_pkg;
  typedef enum logic [1:0] {SEG_PRE, SEG_OP, SEG_ARG, SEG_PL} seg_e;
  typedef enum logic [1:0] {F_IDLE, F_NEXT, F_SHIFT, F_DONE} fsm_e;
  localparam logic ST_OK       = 1'b0;
  localparam logic ST_REJECTED = 1'b1;
endpackage

// File: rtl/cfg_link_sync.sv
module cfg_link_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfg_link_tick.sv
module cfg_link_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] timer;

  // a phase ends when the timer reaches half-1; 0 and 1 both mean one cycle
  assign tick = run && ((half <= DIV_W'(1)) || (timer == half - DIV_W'(1)));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     timer <= '0;
    else if (!run)  timer <= '0;
    else if (tick)  timer <= '0;
    else            timer <= timer + DIV_W'(1);
endmodule

// File: rtl/cfg_link_shift.sv
module cfg_link_shift #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       byte_in,
  input  logic [DIV_W-1:0] half,
  output logic             ser_dat,
  output logic             ser_clk,
  output logic             active,
  output logic             fin
);
  logic       hi;
  logic [7:0] sh;
  logic [2:0] bitn;
  logic       tick;

  cfg_link_tick #(.DIV_W(DIV_W)) tick_i (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (active),
    .half (half),
    .tick (tick)
  );

  // each bit: low phase with data set up, then high phase holding it
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0;
      hi     <= 1'b0;
      sh     <= '0;
      bitn   <= '0;
    end else if (start) begin
      active <= 1'b1;
      hi     <= 1'b0;
      sh     <= byte_in;
      bitn   <= '0;
    end else if (active && tick) begin
      if (!hi) begin
        hi <= 1'b1;
      end else begin
        hi   <= 1'b0;
        sh   <= {sh[6:0], 1'b0};
        bitn <= bitn + 3'd1;
        if (bitn == 3'd7) active <= 1'b0;
      end
    end

  assign fin     = active && tick && hi && (bitn == 3'd7);
  assign ser_clk = active && hi;
  assign ser_dat = active && sh[7];
endmodule

// File: rtl/cfg_link_tx.sv
module cfg_link_tx
  import cfg_link_pkg::*;
#(
  parameter int         DIV_W       = 16,
  parameter int         PAYLOAD_LEN = 64,
  parameter logic [7:0] PREFIX      = 8'h88,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_period,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [7:0]       cmd_opcode,
  input  logic [1:0]       cmd_nargs,
  input  logic [23:0]      cmd_args,
  input  logic             cmd_with_data,
  input  logic             pl_valid,
  output logic             pl_ready,
  input  logic [7:0]       pl_data,
  output logic             link_dat,
  output logic             link_clk,
  input  logic             link_busy,
  output logic             done,
  output logic             status
);
  localparam int PC_W = $clog2(PAYLOAD_LEN + 1);
  localparam logic [PC_W-1:0] PL_LAST = PC_W'(PAYLOAD_LEN);

  fsm_e            st;
  seg_e            seg;
  logic [1:0]      aidx;
  logic [PC_W-1:0] pcnt;
  logic            rej;
  logic            hdr_cur;
  logic [7:0]      op_q;
  logic [1:0]      nargs_q;
  logic [23:0]     args_q;
  logic            pl_q;

  logic            busy_s;
  logic            start;
  logic [7:0]      tx_byte;
  logic            go_done;
  logic            pl_take;
  logic            sh_active;
  logic            sh_fin;
  logic            rej_now;

  cfg_link_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (link_busy),
    .q    (busy_s)
  );

  cfg_link_shift #(.DIV_W(DIV_W)) shift_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .byte_in(tx_byte),
    .half   (half_period),
    .ser_dat(link_dat),
    .ser_clk(link_clk),
    .active (sh_active),
    .fin    (sh_fin)
  );

  // pick the next byte of the frame
  always_comb begin
    start   = 1'b0;
    tx_byte = PREFIX;
    go_done = 1'b0;
    pl_take = 1'b0;
    if (st == F_NEXT) begin
      unique case (seg)
        SEG_PRE: start = 1'b1;
        SEG_OP: begin
          start   = 1'b1;
          tx_byte = op_q;
        end
        SEG_ARG: begin
          if (aidx != nargs_q) begin
            start   = 1'b1;
            tx_byte = args_q[{aidx, 3'b000} +: 8];
          end else if (!pl_q) begin
            go_done = 1'b1;
          end
        end
        SEG_PL: begin
          if (pcnt == PL_LAST) begin
            go_done = 1'b1;
          end else if (pl_valid && !busy_s) begin
            start   = 1'b1;
            tx_byte = pl_data;
            pl_take = 1'b1;
          end
        end
        default: go_done = 1'b1;
      endcase
    end
  end

  assign rej_now = hdr_cur && busy_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= F_IDLE;
      seg     <= SEG_PRE;
      aidx    <= '0;
      pcnt    <= '0;
      rej     <= ST_OK;
      hdr_cur <= 1'b0;
      op_q    <= '0;
      nargs_q <= '0;
      args_q  <= '0;
      pl_q    <= 1'b0;
    end else begin
      unique case (st)
        F_IDLE: if (cmd_valid) begin
          op_q    <= cmd_opcode;
          nargs_q <= cmd_nargs;
          args_q  <= cmd_args;
          pl_q    <= cmd_with_data;
          seg     <= SEG_PRE;
          aidx    <= '0;
          pcnt    <= '0;
          rej     <= ST_OK;
          st      <= F_NEXT;
        end
        F_NEXT: begin
          if (go_done) begin
            st <= F_DONE;
          end else if (start) begin
            st      <= F_SHIFT;
            hdr_cur <= (seg != SEG_PL);
            unique case (seg)
              SEG_PRE: seg  <= SEG_OP;
              SEG_OP:  seg  <= SEG_ARG;
              SEG_ARG: aidx <= aidx + 2'd1;
              default: pcnt <= pcnt + PC_W'(1);
            endcase
          end else if (seg == SEG_ARG) begin
            seg <= SEG_PL;
          end
        end
        F_SHIFT: begin
          if (rej_now) rej <= ST_REJECTED;
          if (sh_fin) st <= (rej || rej_now) ? F_DONE : F_NEXT;
        end
        default: st <= F_IDLE;
      endcase
    end

  assign cmd_ready = (st == F_IDLE);
  assign pl_ready  = pl_take;
  assign done      = (st == F_DONE);
  assign status    = rej;
endmodule

// File: rtl/cfg_link_tx_chk.sv
module cfg_link_tx_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] half_period,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             pl_valid,
  input logic             pl_ready,
  input logic             link_dat,
  input logic             link_clk,
  input logic             done
);
  logic [DIV_W-1:0] hcnt;
  logic [DIV_W-1:0] eff_half;

  assign eff_half = (half_period <= DIV_W'(1)) ? DIV_W'(1) : half_period;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        hcnt <= '0;
    else if (!link_clk) hcnt <= '0;
    else if (hcnt != '1) hcnt <= hcnt + DIV_W'(1);

  assert_dat_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (link_clk && $past(link_clk)) |-> $stable(link_dat));

  assert_high_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    link_clk |-> (hcnt < eff_half));

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!link_clk && !link_dat));

  assert_take_rules_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready |-> (pl_valid && !link_clk));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ready_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && cmd_valid) |=> !cmd_ready);
endmodule

bind cfg_link_tx cfg_link_tx_chk #(.DIV_W(DIV_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .half_period(half_period),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .pl_valid   (pl_valid),
  .pl_ready   (pl_ready),
  .link_dat   (link_dat),
  .link_clk   (link_clk),
  .done       (done)
);

// File: tb/cfg_link_tx_tb_top.sv
module cfg_link_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 16;
  localparam int PLEN       = 64;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] half_period = 16'd2;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [7:0]       cmd_opcode = '0;
  logic [1:0]       cmd_nargs = '0;
  logic [23:0]      cmd_args = '0;
  logic             cmd_with_data = 1'b0;
  logic             pl_valid = 1'b0;
  logic             pl_ready;
  logic [7:0]       pl_data = '0;
  logic             link_dat;
  logic             link_clk;
  logic             link_busy = 1'b0;
  logic             done;
  logic             status;

  cfg_link_tx #(.DIV_W(DIV_W), .PAYLOAD_LEN(PLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .half_period(half_period),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
    .cmd_nargs(cmd_nargs), .cmd_args(cmd_args), .cmd_with_data(cmd_with_data),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
    .link_dat(link_dat), .link_clk(link_clk), .link_busy(link_busy),
    .done(done), .status(status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nvec = 0;
  int nbad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // peer model: capture data on each rising link clock, measure high phases
  logic [7:0] rxbuf [0:127];
  int   rxn = 0;
  int   bits = 0;
  logic [7:0] rxsh = '0;
  logic pclk = 1'b0;
  int   hcnt = 0;
  int   hbad = 0;
  int   rises = 0;
  int   exp_half = 2;

  always @(negedge clk) begin
    if (link_clk && !pclk) begin
      rxsh = {rxsh[6:0], link_dat};
      bits++;
      rises++;
      if (bits == 8) begin
        if (rxn < 128) rxbuf[rxn] = rxsh;
        rxn++;
        bits = 0;
      end
    end
    if (link_clk) hcnt++;
    else begin
      if (pclk && hcnt != exp_half) hbad++;
      hcnt = 0;
    end
    pclk = link_clk;
  end

  // payload source with optional gaps in valid
  int  fidx = 0;
  bit  fpend = 1'b0;
  bit  feed_on = 1'b0;
  bit  feed_gap = 1'b0;
  int  fseed = 0;
  int  cyc = 0;

  always @(negedge clk) begin
    cyc++;
    if (fpend) fidx++;
    pl_valid = feed_on && (fidx < PLEN) && !(feed_gap && (cyc % 3 == 0));
    pl_data  = 8'((fidx * 37 + fseed) & 255);
    #1 fpend = pl_valid && pl_ready;
  end

  task automatic start_frame(input logic [7:0] op, input int n, input logic [23:0] a,
                             input bit wd, input int h, input int seed, input bit gap);
    @(negedge clk);
    rxn = 0; bits = 0; hbad = 0;
    fidx = 0; fpend = 1'b0; feed_on = wd; feed_gap = gap; fseed = seed;
    half_period = DIV_W'(h);
    exp_half = (h <= 1) ? 1 : h;
    cmd_opcode = op; cmd_nargs = 2'(n); cmd_args = a; cmd_with_data = wd;
    cmd_valid = 1'b1;
    #1 chk(cmd_ready == 1'b1, "R9 ready before accept", cmd_ready, 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R9 ready low in frame", cmd_ready, 0);
  endtask

  task automatic wait_done(output logic st);
    int t = 0;
    st = 1'b0;
    while (t < 20000) begin
      if (done) break;
      @(negedge clk);
      t++;
    end
    chk(done == 1'b1, "R8 done seen", done, 1);
    st = status;
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", done, 0);
    chk(cmd_ready == 1'b1, "R9 ready after done", cmd_ready, 1);
    feed_on = 1'b0;
  endtask

  task automatic check_bytes(input logic [7:0] op, input int n, input logic [23:0] a,
                             input bit wd, input int seed);
    int expn = 2 + n + (wd ? PLEN : 0);
    chk(rxn == expn, "R3 R4 byte count", rxn, expn);
    chk(rxbuf[0] == 8'h88, "R1 R2 prefix MSB first", rxbuf[0], 8'h88);
    chk(rxbuf[1] == op, "R2 opcode", rxbuf[1], op);
    for (int k = 0; k < n; k++)
      chk(rxbuf[2+k] == a[8*k +: 8], "R3 argument order", rxbuf[2+k], a[8*k +: 8]);
    if (wd)
      for (int k = 0; k < PLEN; k++)
        chk(rxbuf[2+n+k] == 8'((k * 37 + seed) & 255), "R4 payload byte",
            rxbuf[2+n+k], (k * 37 + seed) & 255);
    chk(hbad == 0, "R5 high phase length", hbad, 0);
  endtask

  task automatic full_frame(input logic [7:0] op, input int n, input logic [23:0] a,
                            input bit wd, input int h, input int seed, input bit gap);
    logic st;
    start_frame(op, n, a, wd, h, seed, gap);
    wait_done(st);
    chk(st == 1'b0, "R8 status OK", st, 0);
    check_bytes(op, n, a, wd, seed);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic st;
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 R5 reset state
    chk(cmd_ready == 1'b1, "R9 reset ready", cmd_ready, 1);
    chk(done == 1'b0, "R9 reset done", done, 0);
    chk(link_clk == 1'b0, "R5 reset clk", link_clk, 0);
    chk(link_dat == 1'b0, "R5 reset dat", link_dat, 0);
    chk(pl_ready == 1'b0, "R4 reset take", pl_ready, 0);

    // sweep divider and argument count
    for (int h = 0; h <= 3; h++)
      for (int n = 0; n <= 3; n++)
        full_frame(8'(8'hB8 + h * 4 + n), n, 24'h123456 + 24'(h * 3 + n), 1'b0, h, 0, 1'b0);

    // fixed unlock style argument patterns
    full_frame(8'h37, 2, 24'h0006D8, 1'b0, 2, 0, 1'b0);
    full_frame(8'h25, 2, 24'h0099FA, 1'b0, 3, 0, 1'b0);

    // payload frames, steady and gappy source (R4)
    full_frame(8'h98, 3, 24'h050000, 1'b1, 2, 11, 1'b0);
    full_frame(8'h98, 3, 24'h0A0040, 1'b1, 1, 77, 1'b1);

    // R6: busy already high when the prefix goes out
    link_busy = 1'b1;
    start_frame(8'hB8, 3, 24'hABCDEF, 1'b0, 2, 0, 1'b0);
    wait_done(st);
    chk(st == 1'b1, "R6 reject on prefix", st, 1);
    chk(rxn == 1, "R6 truncated after prefix", rxn, 1);
    link_busy = 1'b0;

    // R6: busy raised during opcode byte
    start_frame(8'hD4, 3, 24'hABCDEF, 1'b0, 2, 0, 1'b0);
    while (rxn < 1) @(negedge clk);
    link_busy = 1'b1;
    wait_done(st);
    link_busy = 1'b0;
    chk(st == 1'b1, "R6 reject on opcode", st, 1);
    chk(rxn == 2, "R6 truncated after opcode", rxn, 2);

    // R6: busy raised during middle argument byte
    start_frame(8'hE2, 3, 24'h332211, 1'b0, 3, 0, 1'b0);
    while (rxn < 3) @(negedge clk);
    link_busy = 1'b1;
    wait_done(st);
    link_busy = 1'b0;
    chk(st == 1'b1, "R6 reject on argument", st, 1);
    chk(rxn == 4, "R6 truncated after argument", rxn, 4);

    // status returns to OK on the next clean frame
    full_frame(8'hA1, 0, 24'h0, 1'b0, 2, 0, 1'b0);

    // R7: busy during payload pauses the link clock
    start_frame(8'h98, 3, 24'h070000, 1'b1, 2, 5, 1'b0);
    while (rxn < 15) @(negedge clk);
    link_busy = 1'b1;
    repeat (16 * 2 + 8) @(negedge clk);
    r0 = rises;
    repeat (100) @(negedge clk);
    chk(rises == r0, "R7 no clock edge while busy", rises - r0, 0);
    chk(cmd_ready == 1'b0, "R9 ready low during pause", cmd_ready, 0);
    link_busy = 1'b0;
    wait_done(st);
    chk(st == 1'b0, "R7 status OK after pause", st, 0);
    check_bytes(8'h98, 3, 24'h070000, 1'b1, 5);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule